// File: doc/BRIEF.md
# Balanced Serial Link Frame Encoder

This block is the transmit-side framer of a parallel-to-serial link. On every clock it turns one 16-bit user word, with a flag bit, into a 20-bit line frame. A downstream serializer shifts that frame out. The 20-bit frame is 5/4 of the user width.

There are four frame kinds:

- **Data frame.** Carries the full word and the flag as a 17th bit.
- **Control frame.** Carries only the low 14 bits of the word.
- **Two fill frames.** Sent in any cycle with nothing to transmit, so that bit and frame alignment are never lost. They also serve as the training words of the link startup handshake. A select pin picks which of the two is sent.

The header takes the top four bits of each frame. Its middle two bits always differ, which gives the receiver a frame-boundary marker. The encoder keeps the line free of DC content on its own. It tracks a signed running disparity and complements the whole frame whenever sending it as built would push the line further from balance. Arbitrary user data is therefore accepted with no coding by the user.

The input side is a valid/ready stream with no back-pressure. `ready_o` is low only while reset is applied, and is high from the first clock edge after reset is released. A word presented with `valid_i` high in any ready cycle is consumed in that cycle. The control strobe needs no handshake and is taken whenever it is high. The output is one frame per clock and carries no valid: every cycle produces a frame.

Top module: `dcb_frame_encoder`

## Requirements
- R1: With `valid_i` high and `ctrl_i` low, the uncomplemented frame is `{1'b1, 2'b01, flag_i, data_i[15:0]}`. Bit 19 is the most significant bit.
- R2: With `ctrl_i` high, the uncomplemented frame is `{4'b0011, 2'b10, data_i[13:0]}`. This holds whatever the values of `valid_i`, `flag_i` and `data_i[15:14]`.
- R3: With both `ctrl_i` and `valid_i` low, the uncomplemented frame is `{4'b0010, code}`. `code` is 16'hFF00 when `train_sel_i` is 0 and 16'hF0F0 when it is 1. `data_i` and `flag_i` have no effect.
- R4: Let d be 2×(number of ones in the uncomplemented frame) − 20, and rd the running disparity before this frame. All 20 bits are complemented exactly when rd is nonzero and d has the same strict sign as rd.
- R5: The running disparity starts at 0 after reset. After each frame, the 2×ones − 20 of the frame actually sent is added to it.
- R6: The running disparity, summed over the frames sent since reset, always stays within −18 to +18.
- R7: In every output frame, bits 18 and 17 differ. The value 01 marks an uncomplemented frame and 10 a complemented one.
- R8: The frame built from the inputs sampled at a rising edge appears on `frame_o` right after that edge, so there is one cycle of latency and one frame per clock.
- R9: While `rst` is sampled high, `frame_o` becomes 20'h2FF00 and `ready_o` becomes 0.
- R10: `ready_o` is 1 in every cycle whose preceding edge saw `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | 16 | User word |
| flag_i | input | 1 | Extra user bit for data frames |
| valid_i | input | 1 | User word is valid |
| ctrl_i | input | 1 | Send the low 14 bits as a control word; takes priority over `valid_i` |
| train_sel_i | input | 1 | Selects which fill code is sent while idle |
| ready_o | output | 1 | Stream ready; low only during reset |
| frame_o | output | 20 | Registered, balanced line frame |

## Verification
Every result of this block lands one rising edge after its inputs:

- the frame contents,
- the polarity choice,
- the disparity it feeds,
- the reset frame, and
- `ready_o`.

The bench drives each input set at a falling edge and compares `frame_o` and `ready_o` at the next falling edge. That sampling point falls after exactly one register stage.

The bench keeps its own running disparity, advanced by the frame it expects. Any wrong polarity decision therefore shows up both in the frame where it occurs and in the choices that follow.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned HDR_W = 4;
  localparam int unsigned EXT_W = 2;

  // true-polarity header codes {type_hi, 0, 1, type_lo}
  localparam logic [HDR_W-1:0] HDR_FILL = 4'b0010;
  localparam logic [HDR_W-1:0] HDR_CTRL = 4'b0011;
  localparam logic [EXT_W-1:0] CTRL_EXT = 2'b10;

  typedef enum logic [1:0] {
    K_FILL = 2'd0,
    K_CTRL = 2'd1,
    K_DATA = 2'd2
  } frame_kind_e;

  function automatic logic [HDR_W-1:0] data_hdr(input logic flag);
    return {1'b1, 2'b01, flag};
  endfunction
endpackage

// File: rtl/dcb_frame_builder.sv
module dcb_frame_builder
  import dcb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] FILL0 = 16'hFF00,
  parameter logic [DATA_W-1:0] FILL1 = 16'hF0F0,
  localparam int unsigned FRAME_W = DATA_W + HDR_W,
  localparam int unsigned CTRL_W  = DATA_W - EXT_W
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               flag_i,
  input  logic               valid_i,
  input  logic               ctrl_i,
  input  logic               train_sel_i,
  output logic [FRAME_W-1:0] frame_true_o
);
  frame_kind_e kind;

  // control outranks data; otherwise idle fill
  always_comb begin
    if (ctrl_i)       kind = K_CTRL;
    else if (valid_i) kind = K_DATA;
    else              kind = K_FILL;
  end

  always_comb begin
    unique case (kind)
      K_DATA:  frame_true_o = {data_hdr(flag_i), data_i};
      K_CTRL:  frame_true_o = {HDR_CTRL, CTRL_EXT, data_i[CTRL_W-1:0]};
      default: frame_true_o = {HDR_FILL, train_sel_i ? FILL1 : FILL0};
    endcase
  end
endmodule

// File: rtl/dcb_disparity.sv
module dcb_disparity #(
  parameter int unsigned W = 20,
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned DW = CW + 1
) (
  input  logic [W-1:0]         vec_i,
  output logic signed [DW-1:0] disp_o
);
  logic [CW-1:0] acc [W+1];

  assign acc[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_cnt
    assign acc[g+1] = acc[g] + CW'(vec_i[g]);
  end

  // 2*ones - W
  assign disp_o = $signed({acc[W], 1'b0}) - DW'(W);
endmodule

// File: rtl/dcb_polarity.sv
module dcb_polarity #(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned DW = 6,
  parameter int unsigned RD_W = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FRAME_W-1:0]         frame_true_i,
  input  logic signed [DW-1:0]       disp_i,
  output logic [FRAME_W-1:0]         frame_line_o,
  output logic signed [RD_W-1:0]     rd_o
);
  logic signed [RD_W-1:0] rd_q;
  logic signed [RD_W-1:0] d_ext;
  logic                   flip;

  assign d_ext = RD_W'(disp_i);
  assign flip  = ((rd_q > 0) && (d_ext > 0)) || ((rd_q < 0) && (d_ext < 0));
  assign frame_line_o = flip ? ~frame_true_i : frame_true_i;

  always_ff @(posedge clk) begin
    if (rst)       rd_q <= '0;
    else if (flip) rd_q <= rd_q - d_ext;
    else           rd_q <= rd_q + d_ext;
  end

  assign rd_o = rd_q;
endmodule

// File: rtl/dcb_frame_encoder.sv
module dcb_frame_encoder
  import dcb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] FILL0 = 16'hFF00,
  parameter logic [DATA_W-1:0] FILL1 = 16'hF0F0,
  localparam int unsigned FRAME_W = DATA_W + HDR_W,
  localparam int unsigned DW = $clog2(FRAME_W + 1) + 1,
  localparam int unsigned RD_W = DW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               flag_i,
  input  logic               valid_i,
  input  logic               ctrl_i,
  input  logic               train_sel_i,
  output logic               ready_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [FRAME_W-1:0] RST_FRAME = {HDR_FILL, FILL0};

  logic [FRAME_W-1:0]     frame_true;
  logic [FRAME_W-1:0]     frame_line;
  logic signed [DW-1:0]   disp;
  logic signed [RD_W-1:0] rd_q;
  logic                   ready_q;
  logic [FRAME_W-1:0]     frame_q;

  dcb_frame_builder #(
    .DATA_W(DATA_W), .FILL0(FILL0), .FILL1(FILL1)
  ) u_build (
    .data_i(data_i), .flag_i(flag_i), .valid_i(valid_i),
    .ctrl_i(ctrl_i), .train_sel_i(train_sel_i),
    .frame_true_o(frame_true)
  );

  dcb_disparity #(.W(FRAME_W)) u_disp (
    .vec_i(frame_true), .disp_o(disp)
  );

  dcb_polarity #(.FRAME_W(FRAME_W), .DW(DW), .RD_W(RD_W)) u_pol (
    .clk(clk), .rst(rst), .frame_true_i(frame_true), .disp_i(disp),
    .frame_line_o(frame_line), .rd_o(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= RST_FRAME;
      ready_q <= 1'b0;
    end else begin
      frame_q <= frame_line;
      ready_q <= 1'b1;
    end
  end

  assign frame_o = frame_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/dcb_frame_encoder_chk.sv
module dcb_frame_encoder_chk #(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned RD_W = 7
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ready_o,
  input logic [FRAME_W-1:0]     frame_o,
  input logic signed [RD_W-1:0] rd_q
);
  int rd_i;
  int disp_i;
  logic inv;

  always_comb begin
    rd_i   = int'(rd_q);
    disp_i = 2 * $countones(frame_o) - int'(FRAME_W);
    inv    = (frame_o[FRAME_W-2 -: 2] == 2'b10);
  end

  a_r7_marker: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (frame_o[FRAME_W-2] != frame_o[FRAME_W-3]));

  a_r6_rd_bound: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_i <= 18 && rd_i >= -18));

  a_r5_rd_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_i == $past(rd_i) + disp_i));

  a_r4_flip_when: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && inv) |->
      (($past(rd_i) > 0 && disp_i < 0) || ($past(rd_i) < 0 && disp_i > 0)));

  a_r4_keep_when: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !inv) |->
      !(($past(rd_i) > 0 && disp_i > 0) || ($past(rd_i) < 0 && disp_i < 0)));

  a_r10_ready: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ready_o);
endmodule

bind dcb_frame_encoder dcb_frame_encoder_chk #(.FRAME_W(FRAME_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst(rst), .ready_o(ready_o), .frame_o(frame_o), .rd_q(rd_q)
);

// File: tb/sim_dcb_frame_encoder.sv
module sim_dcb_frame_encoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] data_i = '0;
  logic        flag_i = 1'b0;
  logic        valid_i = 1'b0;
  logic        ctrl_i = 1'b0;
  logic        train_sel_i = 1'b0;
  logic        ready_o;
  logic [19:0] frame_o;

  int checks = 0;
  int fails = 0;
  int rd_m = 0;
  int rd_obs = 0;
  bit done = 1'b0;

  dcb_frame_encoder u0 (
    .clk(clk), .rst(rst), .data_i(data_i), .flag_i(flag_i),
    .valid_i(valid_i), .ctrl_i(ctrl_i), .train_sel_i(train_sel_i),
    .ready_o(ready_o), .frame_o(frame_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int ones20(input logic [19:0] v);
    int n = 0;
    for (int i = 0; i < 20; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive one input set, advance one edge, compare the frame
  task automatic send(input logic [15:0] d, input bit f, input bit v, input bit c, input bit t);
    logic [19:0] tru;
    logic [19:0] exp;
    string tag;
    int dd;
    data_i = d; flag_i = f; valid_i = v; ctrl_i = c; train_sel_i = t;
    if (c)      begin tru = {4'b0011, 2'b10, d[13:0]}; tag = "R2 R8"; end
    else if (v) begin tru = {1'b1, 2'b01, f, d};       tag = "R1 R8"; end
    else        begin tru = {4'b0010, t ? 16'hF0F0 : 16'hFF00}; tag = "R3 R8"; end
    dd = 2 * ones20(tru) - 20;
    if ((rd_m > 0 && dd > 0) || (rd_m < 0 && dd < 0)) begin
      exp = ~tru; tag = {tag, " R4 R5"};
    end else begin
      exp = tru;  tag = {tag, " R5"};
    end
    rd_m += 2 * ones20(exp) - 20;
    tick();
    chk(frame_o == exp, tag, frame_o, exp);
    chk(ready_o == 1'b1, "R10", 20'(ready_o), 20'h1);
    chk(frame_o[18] != frame_o[17], "R7", frame_o, exp);
    rd_obs += 2 * ones20(frame_o) - 20;
    chk(rd_obs <= 18 && rd_obs >= -18, "R6", 20'(rd_obs), 20'd18);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    tick();
    tick();
    chk(frame_o == 20'h2FF00, "R9", frame_o, 20'h2FF00);
    chk(ready_o == 1'b0, "R9", 20'(ready_o), 20'h0);
    rd_m = 0;
    rd_obs = 0;
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [6];
    logic [15:0] lf;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5A5;
    pats[3] = 16'hC000; pats[4] = 16'h3FFF; pats[5] = 16'h8001;
    @(negedge clk);
    do_reset();

    // every strobe combination over several words (R1 R2 R3)
    for (int k = 0; k < 6; k++)
      for (int m = 0; m < 16; m++)
        send(pats[k], m[0], m[1], m[2], m[3]);

    // walking ones and zeros in data frames
    for (int b = 0; b < 16; b++) send(16'h1 << b, b[0], 1'b1, 1'b0, 1'b0);
    for (int b = 0; b < 16; b++) send(~(16'h1 << b), b[1], 1'b1, 1'b0, 1'b0);

    // heavy one-sided data pushes the polarity logic (R4 R6)
    for (int i = 0; i < 12; i++) send(16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) send(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)  send(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);

    // idle fill with varying ignored data (R3)
    for (int i = 0; i < 8; i++) send(16'h1234 * 16'(i), i[0], 1'b0, 1'b0, i[1]);

    // mid-run reset (R9), then pseudo-random traffic
    do_reset();
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      send(lf ^ 16'(i * 40503), lf[3], lf[0] | lf[5], lf[1] & lf[7], lf[2]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule